// File: doc/BRIEF.md
# Slip and Stator Frequency Slew Controller

This block is the outer loop of a sensorless induction motor speed controller. On every accepted control sample it advances two state variables: the stator current amplitude and the stator electrical angular frequency. The amplitude moves by a gain times the slip-angle error. That error is the reference angle minus the angle of the internal voltage vector after that vector has been folded into the first quadrant. The frequency slews toward `pole_pairs * speed_ref + slip_ref`. Its slew magnitude is a piecewise-linear function of how far the folded angle lies above a programmable threshold. The two state values feed a reference-vector generator downstream.

Samples arrive on a valid/ready stream. A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high while the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input directly. The result of an accepted sample appears on `is_amp`/`w_es` one clock later with `out_valid` high. It stays there unchanged until `out_ready` takes it. Gains, limits and thresholds are plain control inputs that are read at the moment of acceptance. The reset is synchronous and active low. During reset the control inputs must be stable.

Top module: `slip_slew_ctrl`

## Requirements
- R1: The angle code `alpha_code` covers a full turn in 2^ANG_W steps (bits [ANG_W-1:ANG_W-2] are the quadrant, the low ANG_W-2 bits `r` are the offset). The folded first-quadrant angle is `r` in quadrants 0 and 2 and `2^(ANG_W-2) - r` in quadrants 1 and 3.
- R2: On acceptance, the raw amplitude is `is_amp + ((gain_ki * (alpha_ref - folded)) >>> SH)`. The shift is arithmetic and rounds toward minus infinity.
- R3: The stored amplitude is the raw amplitude clamped into [`is_min`, `is_max`], so it never lies outside the limits.
- R4: The frequency target is `pole_pairs * speed_ref + slip_ref`, saturated to the signed W-bit range.
- R5: The slew magnitude is `((gain_k1 * chi) >>> SH) + gain_k2` when `chi = folded - alpha_min` is positive, and `gain_k2` otherwise. With `gain_k1 = 0` it is a constant `gain_k2`.
- R6: `w_es` moves toward the target by the slew magnitude, or lands exactly on the target when it is closer than that. When the target equals `w_es`, `w_es` is unchanged.
- R7: While `rst_n` is low, `is_amp` loads `is_min`, `w_es` loads `slip_ref` and `out_valid` is 0.
- R8: `in_ready = !out_valid || out_ready`. Outputs change only on acceptance. `out_valid` stays high while `out_ready` is low, and it falls after an `out_ready` cycle with no new acceptance.
- R9: With `speed_ref = 0` and a nonzero slew magnitude, `w_es` settles to `slip_ref` and then stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample can be accepted |
| speed_ref | input | W | Reference rotor speed, signed |
| pole_pairs | input | PW | Pole-pair count, unsigned |
| slip_ref | input | W | Reference slip frequency, signed |
| alpha_code | input | ANG_W | Full-turn angle of internal voltage vector |
| alpha_ref | input | ANG_W-1 | Reference folded angle |
| alpha_min | input | ANG_W-1 | Slew threshold angle |
| gain_ki | input | GW | Amplitude gain, unsigned |
| gain_k1 | input | GW | Slew slope gain, unsigned |
| gain_k2 | input | GW | Slew base rate, unsigned |
| is_min | input | W | Lower amplitude limit, signed |
| is_max | input | W | Upper amplitude limit, signed |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| is_amp | output | W | Stator current amplitude, signed |
| w_es | output | W | Stator angular frequency, signed |

## Verification
The bench aims at the following corner cases:
- Quadrant boundaries of the fold, where a mirrored offset of zero must give a full quarter. A fold that forgot to mirror would drive the amplitude the wrong way in odd quadrants.
- Amplitude steps that overshoot either limit. A design that froze instead of clamping would leave the amplitude stuck short of the limit.
- Frequency errors smaller than the slew magnitude, and an error of exactly zero. A plain sign-times-rate stepper would chatter around the target there.
- Extreme speed and pole-pair values. A design without target saturation would wrap and slew the frequency the wrong way.
- Output back-pressure. A design that ignored it would overwrite a held result.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SLEW_HOLD = 2'd0,
    SLEW_UP   = 2'd1,
    SLEW_DOWN = 2'd2
  } slew_dir_e;
endpackage

// File: rtl/ssc_angle_fold.sv
// Folds a full-turn angle code into the first quadrant, matching the angle
// of a vector whose real and imaginary parts were replaced by magnitudes.
module ssc_angle_fold #(
  parameter int ANG_W = 10
) (
  input  logic [ANG_W-1:0] code,
  output logic [ANG_W-2:0] folded
);
  localparam int AW = ANG_W - 1;
  localparam int QW = ANG_W - 2;
  localparam logic [AW-1:0] QUARTER = AW'(1) << QW;

  logic [AW-1:0] offs;
  logic          mirror;

  assign offs   = {1'b0, code[QW-1:0]};
  assign mirror = code[QW];
  assign folded = mirror ? (QUARTER - offs) : offs;
endmodule

// File: rtl/ssc_amp_step.sv
// One integration step of the stator current amplitude, slip-angle driven.
module ssc_amp_step #(
  parameter int W  = 16,
  parameter int AW = 9,
  parameter int GW = 12,
  parameter int SH = 4
) (
  input  logic signed [W-1:0]  amp_cur,
  input  logic        [GW-1:0] ki,
  input  logic        [AW-1:0] ang_ref,
  input  logic        [AW-1:0] ang_eq,
  input  logic signed [W-1:0]  lim_lo,
  input  logic signed [W-1:0]  lim_hi,
  output logic signed [W-1:0]  amp_nxt
);
  localparam int PRW = GW + AW + 2;
  localparam int SW  = ((PRW > W) ? PRW : W) + 1;

  logic signed [AW:0]     ang_err;
  logic signed [PRW-1:0]  prod;
  logic signed [PRW-1:0]  incr;
  logic signed [SW-1:0]   raw;

  assign ang_err = $signed({1'b0, ang_ref}) - $signed({1'b0, ang_eq});
  assign prod    = PRW'($signed({1'b0, ki})) * PRW'(ang_err);

  generate
    if (SH == 0) begin : g_noshift
      assign incr = prod;
    end else begin : g_shift
      assign incr = prod >>> SH;
    end
  endgenerate

  assign raw = SW'(amp_cur) + SW'(incr);

  always_comb begin
    if (raw < SW'(lim_lo))      amp_nxt = lim_lo;
    else if (raw > SW'(lim_hi)) amp_nxt = lim_hi;
    else                        amp_nxt = raw[W-1:0];
  end
endmodule

// File: rtl/ssc_freq_slew.sv
// One slew step of the stator electrical angular frequency toward its target.
module ssc_freq_slew
  import ssc_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 9,
  parameter int GW = 12,
  parameter int SH = 4,
  parameter int PW = 3
) (
  input  logic signed [W-1:0]  frq_cur,
  input  logic signed [W-1:0]  spd_ref,
  input  logic        [PW-1:0] pairs,
  input  logic signed [W-1:0]  slip,
  input  logic        [GW-1:0] k1,
  input  logic        [GW-1:0] k2,
  input  logic        [AW-1:0] ang_eq,
  input  logic        [AW-1:0] ang_thr,
  output logic signed [W-1:0]  frq_nxt,
  output slew_dir_e            dir
);
  localparam int TW = W + PW + 2;
  localparam int DW = W + 1;
  localparam int MW = GW + AW + 3;
  localparam logic signed [TW-1:0] TMAX = TW'((1 << (W - 1)) - 1);
  localparam logic signed [TW-1:0] TMIN = TW'(-(1 << (W - 1)));

  logic signed [TW-1:0] tgt_wide;
  logic signed [W-1:0]  tgt;
  logic signed [DW-1:0] err;
  logic        [DW-1:0] err_abs;
  logic signed [AW:0]   chi;
  logic signed [MW-1:0] kprod;
  logic signed [MW-1:0] mag;
  logic        [MW-1:0] stp;

  assign tgt_wide = TW'(spd_ref) * TW'($signed({1'b0, pairs})) + TW'(slip);

  always_comb begin
    if (tgt_wide > TMAX)      tgt = TMAX[W-1:0];
    else if (tgt_wide < TMIN) tgt = TMIN[W-1:0];
    else                      tgt = tgt_wide[W-1:0];
  end

  assign err     = DW'(tgt) - DW'(frq_cur);
  assign err_abs = err[DW-1] ? DW'(-err) : DW'(err);

  always_comb begin
    if (err > 0)      dir = SLEW_UP;
    else if (err < 0) dir = SLEW_DOWN;
    else              dir = SLEW_HOLD;
  end

  assign chi   = $signed({1'b0, ang_eq}) - $signed({1'b0, ang_thr});
  assign kprod = MW'($signed({1'b0, k1})) * MW'(chi);

  always_comb begin
    if (chi > 0) mag = (kprod >>> SH) + MW'($signed({1'b0, k2}));
    else         mag = MW'($signed({1'b0, k2}));
  end

  assign stp = (MW'(err_abs) > mag) ? mag : MW'(err_abs);

  always_comb begin
    unique case (dir)
      SLEW_UP:   frq_nxt = frq_cur + W'(stp);
      SLEW_DOWN: frq_nxt = frq_cur - W'(stp);
      default:   frq_nxt = frq_cur;
    endcase
  end
endmodule

// File: rtl/slip_slew_ctrl.sv
module slip_slew_ctrl
  import ssc_pkg::*;
#(
  parameter int W     = 16,
  parameter int ANG_W = 10,
  parameter int GW    = 12,
  parameter int SH    = 4,
  parameter int PW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W-1:0]  speed_ref,
  input  logic        [PW-1:0] pole_pairs,
  input  logic signed [W-1:0]  slip_ref,
  input  logic [ANG_W-1:0]     alpha_code,
  input  logic [ANG_W-2:0]     alpha_ref,
  input  logic [ANG_W-2:0]     alpha_min,
  input  logic [GW-1:0]        gain_ki,
  input  logic [GW-1:0]        gain_k1,
  input  logic [GW-1:0]        gain_k2,
  input  logic signed [W-1:0]  is_min,
  input  logic signed [W-1:0]  is_max,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [W-1:0]  is_amp,
  output logic signed [W-1:0]  w_es
);
  localparam int AW = ANG_W - 1;

  logic [AW-1:0]       alpha_q;
  logic signed [W-1:0] amp_nxt;
  logic signed [W-1:0] frq_nxt;
  slew_dir_e           slew_dir;
  logic                accept;
  logic signed [W-1:0] amp_q;
  logic signed [W-1:0] frq_q;
  logic                ov_q;

  ssc_angle_fold #(.ANG_W(ANG_W)) fold_i (
    .code   (alpha_code),
    .folded (alpha_q)
  );

  ssc_amp_step #(.W(W), .AW(AW), .GW(GW), .SH(SH)) amp_i (
    .amp_cur (amp_q),
    .ki      (gain_ki),
    .ang_ref (alpha_ref),
    .ang_eq  (alpha_q),
    .lim_lo  (is_min),
    .lim_hi  (is_max),
    .amp_nxt (amp_nxt)
  );

  ssc_freq_slew #(.W(W), .AW(AW), .GW(GW), .SH(SH), .PW(PW)) frq_i (
    .frq_cur (frq_q),
    .spd_ref (speed_ref),
    .pairs   (pole_pairs),
    .slip    (slip_ref),
    .k1      (gain_k1),
    .k2      (gain_k2),
    .ang_eq  (alpha_q),
    .ang_thr (alpha_min),
    .frq_nxt (frq_nxt),
    .dir     (slew_dir)
  );

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp_q <= is_min;
      frq_q <= slip_ref;
      ov_q  <= 1'b0;
    end else begin
      if (accept) begin
        amp_q <= amp_nxt;
        frq_q <= frq_nxt;
        ov_q  <= 1'b1;
      end else if (out_ready) begin
        ov_q  <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign is_amp    = amp_q;
  assign w_es      = frq_q;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int W  = 16,
  parameter int AW = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] is_min,
  input logic signed [W-1:0] is_max,
  input logic signed [W-1:0] is_amp,
  input logic signed [W-1:0] w_es,
  input logic [AW-1:0]       alpha_q,
  input logic [1:0]          slew_dir
);
  localparam logic [AW-1:0] QUARTER = AW'(1) << (AW - 1);

  AST_FOLD_IN_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    alpha_q <= QUARTER); // R1

  AST_AMP_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && is_min <= is_max) |=>
      (is_amp >= $past(is_min) && is_amp <= $past(is_max))); // R3

  AST_SLEW_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && slew_dir == 2'd1) |=> (w_es >= $past(w_es))); // R6

  AST_SLEW_DOWN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && slew_dir == 2'd2) |=> (w_es <= $past(w_es))); // R6

  AST_SLEW_HOLD_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && slew_dir == 2'd0) |=> $stable(w_es)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(is_amp) && $stable(w_es))); // R8

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R8
endmodule

bind slip_slew_ctrl ssc_checker #(.W(W), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .is_min    (is_min),
  .is_max    (is_max),
  .is_amp    (is_amp),
  .w_es      (w_es),
  .alpha_q   (alpha_q),
  .slew_dir  (slew_dir)
);

// File: tb/slip_slew_ctrl_tb_top.sv
module slip_slew_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int ANG_W = 10;
  localparam int GW = 12;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] speed_ref = '0;
  logic [PW-1:0] pole_pairs = 3'd2;
  logic signed [W-1:0] slip_ref = 16'sd300;
  logic [ANG_W-1:0] alpha_code = '0;
  logic [ANG_W-2:0] alpha_ref = 9'd100;
  logic [ANG_W-2:0] alpha_min = 9'd50;
  logic [GW-1:0] gain_ki = 12'd16;
  logic [GW-1:0] gain_k1 = 12'd16;
  logic [GW-1:0] gain_k2 = 12'd20;
  logic signed [W-1:0] is_min = 16'sd200;
  logic signed [W-1:0] is_max = 16'sd3000;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [W-1:0] is_amp;
  logic signed [W-1:0] w_es;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  longint m_is, m_wes;
  bit m_ov;

  always #(CLK_PERIOD/2) clk = ~clk;

  slip_slew_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .speed_ref(speed_ref), .pole_pairs(pole_pairs), .slip_ref(slip_ref),
    .alpha_code(alpha_code), .alpha_ref(alpha_ref), .alpha_min(alpha_min),
    .gain_ki(gain_ki), .gain_k1(gain_k1), .gain_k2(gain_k2),
    .is_min(is_min), .is_max(is_max), .out_valid(out_valid),
    .out_ready(out_ready), .is_amp(is_amp), .w_es(w_es)
  );

  function automatic longint fold_ang(input longint code);
    longint q = (code >> 8) & 1;
    longint r = code & 255;
    return q ? 256 - r : r;
  endfunction

  function automatic longint next_amp(input longint cur);
    longint aeq = fold_ang(longint'(alpha_code));
    longint beta = longint'(alpha_ref) - aeq;
    longint raw = cur + ((longint'(gain_ki) * beta) >>> 4);
    longint lo = longint'(is_min);
    longint hi = longint'(is_max);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  function automatic longint slew_mag();
    longint chi = fold_ang(longint'(alpha_code)) - longint'(alpha_min);
    if (chi > 0) return ((longint'(gain_k1) * chi) >>> 4) + longint'(gain_k2);
    return longint'(gain_k2);
  endfunction

  function automatic longint freq_target();
    longint t = longint'(pole_pairs) * longint'(speed_ref) + longint'(slip_ref);
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  function automatic longint next_freq(input longint cur);
    longint d = freq_target() - cur;
    longint a = (d < 0) ? -d : d;
    longint m = slew_mag();
    longint s = (a < m) ? a : m;
    if (d > 0) return cur + s;
    if (d < 0) return cur - s;
    return cur;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // Called at a negedge; drives handshake, advances model, samples at next negedge.
  task automatic cyc(input bit iv, input bit orr, input string req);
    bit acc;
    in_valid = iv;
    out_ready = orr;
    acc = iv && (!m_ov || orr);
    if (acc) begin
      m_is = next_amp(m_is);
      m_wes = next_freq(m_wes);
      m_ov = 1'b1;
    end else if (orr) begin
      m_ov = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, longint'(is_amp), m_is);
    check(req, longint'(w_es), m_wes);
    check(req, longint'(out_valid), longint'(m_ov));
  endtask

  task automatic rand_cfg();
    is_min = W'($signed(32'($urandom_range(0, 1000))));
    is_max = is_min + W'($signed(32'($urandom_range(0, 4000))));
    gain_ki = GW'($urandom_range(0, 4095));
    gain_k1 = GW'($urandom_range(0, 600));
    gain_k2 = GW'($urandom_range(0, 800));
    alpha_ref = 9'($urandom_range(0, 256));
    alpha_min = 9'($urandom_range(0, 256));
    slip_ref = W'($signed(32'($urandom_range(0, 2000)) - 500));
    pole_pairs = PW'($urandom_range(0, 7));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset loads limits and slip
    check("R7", longint'(is_amp), 200);
    check("R7", longint'(w_es), 300);
    check("R7", longint'(out_valid), 0);
    check("R8", longint'(in_ready), 1);
    rst_n = 1'b1;
    m_is = 200; m_wes = 300; m_ov = 1'b0;

    // R1: quadrant boundaries, odd quadrant with zero offset folds to a full quarter
    foreach (alpha_code[i]) ;
    alpha_ref = 9'd256; gain_ki = 12'd16; is_min = -16'sd30000; is_max = 16'sd30000;
    alpha_code = 10'd256;  // quadrant 1, r=0 -> folded 256, error 0
    cyc(1'b1, 1'b1, "R1");
    check("R1", longint'(is_amp), 200);
    alpha_code = 10'd512;  // quadrant 2, r=0 -> folded 0, error 256 -> +256
    cyc(1'b1, 1'b1, "R1");
    check("R1", longint'(is_amp), 456);
    alpha_code = 10'd1023; // quadrant 3, r=255 -> folded 1 -> +255
    cyc(1'b1, 1'b1, "R2");
    check("R2", longint'(is_amp), 711);
    // R2: negative error with floor shift: ki=1, error -1 -> -1
    gain_ki = 12'd1; alpha_ref = 9'd0; alpha_code = 10'd1;
    cyc(1'b1, 1'b1, "R2");
    check("R2", longint'(is_amp), 710);

    // R3: overshoot both limits
    is_min = 16'sd100; is_max = 16'sd800; gain_ki = 12'd4095; alpha_ref = 9'd256; alpha_code = 10'd0;
    cyc(1'b1, 1'b1, "R3");
    check("R3", longint'(is_amp), 800);
    alpha_ref = 9'd0; alpha_code = 10'd200;
    cyc(1'b1, 1'b1, "R3");
    check("R3", longint'(is_amp), 100);

    // R4: target saturation at the positive extreme
    speed_ref = 16'sd32767; pole_pairs = 3'd7; slip_ref = 16'sd100;
    gain_k1 = 12'd0; gain_k2 = 12'd4095; alpha_code = 10'd0; alpha_min = 9'd0;
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, "R4");
    check("R4", longint'(w_es), 32767);
    speed_ref = -16'sd32768;
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, "R4");
    check("R4", longint'(w_es), -32768);

    // R5: K1 = 0 gives constant slew K2 regardless of angle
    speed_ref = 16'sd1000; pole_pairs = 3'd1; slip_ref = 16'sd0; gain_k2 = 12'd7;
    alpha_code = 10'd200; alpha_min = 9'd10;
    cyc(1'b1, 1'b1, "R5");
    check("R5", longint'(w_es), -32768 + 7);
    // R5: slope term above threshold: k1=32, chi=100 -> 200+7
    gain_k1 = 12'd32; alpha_min = 9'd100;
    cyc(1'b1, 1'b1, "R5");
    check("R5", longint'(w_es), -32768 + 7 + 207);

    // R6: lands exactly on target, then holds
    gain_k1 = 12'd0; gain_k2 = 12'd4095;
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, "R6");
    check("R6", longint'(w_es), 1000);
    cyc(1'b1, 1'b1, "R6");
    check("R6", longint'(w_es), 1000);

    // R8: back-pressure holds the result and stalls input
    alpha_code = 10'd0; alpha_ref = 9'd50; gain_ki = 12'd16; is_min = 16'sd0; is_max = 16'sd5000;
    cyc(1'b1, 1'b0, "R8");
    speed_ref = 16'sd0;
    cyc(1'b1, 1'b0, "R8");
    check("R8", longint'(in_ready), 0);
    cyc(1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b1, "R8");
    check("R8", longint'(out_valid), 0);

    // R9: zero speed settles on slip reference
    slip_ref = 16'sd450; speed_ref = 16'sd0; gain_k2 = 12'd25; gain_k1 = 12'd0;
    for (int i = 0; i < 200; i++) cyc(1'b1, 1'b1, "R9");
    check("R9", longint'(w_es), 450);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) rand_cfg();
      speed_ref = W'($signed(32'($urandom_range(0, 8000)) - 4000));
      alpha_code = ANG_W'($urandom_range(0, 1023));
      cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0), "R2/R6 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule